// File: doc/BRIEF.md
# Board Control Register Block

This block is the small control and status window that board software uses to learn about the board it runs on. It sits on a plain 32-bit register bus made of an offset, a write strobe with write data, and a read strobe with read data. It answers with a fixed build identifier and the processor clock rate in hertz. It keeps a writable register whose bits drive the board LEDs, and it reports a bank of DIP switches. A write of one exact key to a command offset issues a single board reset request towards an external reset controller.

The block decodes a 64 KiB window. All 16 offset bits take part in the decode, so aliases such as 0x108 are unmapped. The bus has no back-pressure: every strobe is accepted in the cycle it is seen. Read data is registered and appears the cycle after the read strobe. It holds that value until the next read. The switch inputs are asynchronous to the bus clock and pass through a synchroniser before they can be read.

Top module: `brd_ctrl_regs`

## Requirements
- R1: A read at offset 0x0000 returns the build word 0x09272011.
- R2: A read at offset 0x0004 returns the processor clock rate, 10,000,000 (0x00989680).
- R3: Offset 0x0008 holds the LED register. A write stores the low LED_W data bits, and led_out shows them from the cycle after the write. A 1 bit means that LED is lit. A read returns them zero-extended.
- R4: A read at offset 0x000C returns the switch inputs zero-extended, where 1 means on. The inputs pass through a two-flop synchroniser, so a change shows in a read issued two cycles after it.
- R5: A read at any other offset returns zero. This includes the command offset 0x0010, the alias 0x0108 and the top word 0xFFFC.
- R6: A write of exactly 0x0000DEAD to offset 0x0010 raises board_rst_req for exactly one cycle, the cycle after the write.
- R7: A write of any other value to offset 0x0010, such as 0x0000DEAE or 0x0001DEAD, produces no reset request and leaves the LED register unchanged.
- R8: A write to any offset other than 0x0008 and 0x0010 leaves the LED register and led_out unchanged and produces no reset request.
- R9: While rst_n is low, and right after it rises, led_out, bus_rdata and board_rst_req are all zero.
- R10: bus_rdata is registered. It is valid in the cycle after bus_ren and holds its value while bus_ren stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte offset within the 64 KiB window |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| dip_in | input | SW_W (8) | Asynchronous switch inputs, 1 = on |
| led_out | output | LED_W (8) | LED drive, 1 = lit |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The key check writes the exact key and then near misses. The near misses are a value one above the key and a value with an extra high bit set. Together they show whether the compare covers every data bit or only the low half-word. LED patterns of alternating bits and all ones show that each bit is stored and driven on its own. Reads of aliased and top-of-window offsets show whether the decode looks at all 16 offset bits. Switch values are read two cycles after they change, and a following read confirms the delay of the synchroniser.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int WIN_AW = 16;
  localparam logic [WIN_AW-1:0] OFS_ID  = 16'h0000;
  localparam logic [WIN_AW-1:0] OFS_CLK = 16'h0004;
  localparam logic [WIN_AW-1:0] OFS_LED = 16'h0008;
  localparam logic [WIN_AW-1:0] OFS_SW  = 16'h000C;
  localparam logic [WIN_AW-1:0] OFS_CMD = 16'h0010;

  typedef enum logic [2:0] {
    SEL_ID, SEL_CLK, SEL_LED, SEL_SW, SEL_CMD, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [WIN_AW-1:0] ofs);
    case (ofs)
      OFS_ID:  return SEL_ID;
      OFS_CLK: return SEL_CLK;
      OFS_LED: return SEL_LED;
      OFS_SW:  return SEL_SW;
      OFS_CMD: return SEL_CMD;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          LED_W    = 8,
  parameter int          SW_W     = 8,
  parameter logic [31:0] BUILD_ID = 32'h0927_2011,
  parameter int unsigned CLK_HZ   = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wen,
  input  logic              ren,
  input  logic [LED_W-1:0]  led_wdata,
  input  logic [SW_W-1:0]   sw_sync,
  output logic [LED_W-1:0]  led_q,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int LED_PAD = DATA_W - LED_W;
  localparam int SW_PAD  = DATA_W - SW_W;

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) led_q <= '0;
    else if (wen && sel == SEL_LED) led_q <= led_wdata;
  end

  always_comb begin
    case (sel)
      SEL_ID:  rd_mux = DATA_W'(BUILD_ID);
      SEL_CLK: rd_mux = DATA_W'(CLK_HZ);
      SEL_LED: rd_mux = {{LED_PAD{1'b0}}, led_q};
      SEL_SW:  rd_mux = {{SW_PAD{1'b0}}, sw_sync};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (ren) rdata_q <= rd_mux;
  end

  // R8: LED register only moves on a write to its own offset
  p_led_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen && sel == SEL_LED) |=> $stable(led_q));

  // R10: read data held between read strobes
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata_q));

  // R5: unmapped and command offsets read zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && (sel == SEL_NONE || sel == SEL_CMD)) |=> rdata_q == '0);

  // R1: build word
  p_build_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && sel == SEL_ID) |=> rdata_q == DATA_W'(BUILD_ID));
endmodule

// File: rtl/bcr_rstcmd.sv
module bcr_rstcmd #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY  = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else req_q <= cmd_wr && (wdata == KEY);
  end

  // R6: request lasts a single cycle
  p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int          SW_W        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] BUILD_ID    = 32'h0927_2011,
  parameter int unsigned CLK_HZ      = 10_000_000,
  parameter logic [31:0] RST_KEY     = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ren,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   dip_in,
  output logic [LED_W-1:0]  led_out,
  output logic              board_rst_req
);
  reg_sel_e        sel;
  logic [SW_W-1:0] sw_sync;

  assign sel = decode_ofs(bus_addr);

  bcr_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(dip_in), .q_sync(sw_sync)
  );

  bcr_regs #(
    .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W),
    .BUILD_ID(BUILD_ID), .CLK_HZ(CLK_HZ)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wen(bus_wen), .ren(bus_ren),
    .led_wdata(bus_wdata[LED_W-1:0]), .sw_sync(sw_sync),
    .led_q(led_out), .rdata_q(bus_rdata)
  );

  bcr_rstcmd #(.DATA_W(DATA_W), .KEY(DATA_W'(RST_KEY))) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(bus_wen && sel == SEL_CMD),
    .wdata(bus_wdata), .req_q(board_rst_req)
  );

  // R6/R7: a request only follows an exact key write at the command offset
  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> $past(bus_wen && bus_addr == OFS_CMD
                            && bus_wdata == DATA_W'(RST_KEY)));
endmodule

// File: tb/sim_brd_ctrl_regs.sv
module sim_brd_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  dip_in = '0;
  logic [7:0]  led_out;
  logic        board_rst_req;

  int total = 0;
  int bad = 0;
  int pulse_cnt = 0;

  always #2.5 clk = ~clk;

  brd_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .dip_in(dip_in), .led_out(led_out), .board_rst_req(board_rst_req)
  );

  always @(posedge clk) if (board_rst_req) pulse_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    chk("R9 led", {24'h0, led_out}, 32'h0);
    chk("R9 rdata", bus_rdata, 32'h0);
    chk("R9 req", {31'h0, board_rst_req}, 32'h0);
  endtask

  task automatic t_consts();
    logic [31:0] v;
    rd(16'h0000, v); chk("R1 build", v, 32'h0927_2011);
    rd(16'h0004, v); chk("R2 clock", v, 32'd10_000_000);
    repeat (3) @(negedge clk);
    chk("R10 hold", bus_rdata, 32'd10_000_000);
  endtask

  task automatic t_led();
    logic [31:0] v;
    wr(16'h0008, 32'hFFFF_FFA5);
    chk("R3 led out", {24'h0, led_out}, 32'hA5);
    rd(16'h0008, v); chk("R3 led read", v, 32'hA5);
    wr(16'h0008, 32'h0000_005A);
    chk("R3 led out2", {24'h0, led_out}, 32'h5A);
    wr(16'h0008, 32'h0000_00FF);
    rd(16'h0008, v); chk("R3 led all", v, 32'hFF);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] v;
    int p0 = pulse_cnt;
    wr(16'h0000, 32'h0000_0011);
    wr(16'h000C, 32'h0000_0022);
    wr(16'h0108, 32'h0000_0033);
    wr(16'hFFFC, 32'h0000_DEAD);
    chk("R8 led out", {24'h0, led_out}, 32'hFF);
    rd(16'h0008, v); chk("R8 led read", v, 32'hFF);
    rd(16'h0000, v); chk("R8 build kept", v, 32'h0927_2011);
    chk("R8 no pulse", pulse_cnt - p0, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(16'h0010, v); chk("R5 cmd ofs", v, 32'h0);
    rd(16'h0108, v); chk("R5 alias", v, 32'h0);
    rd(16'hFFFC, v); chk("R5 top", v, 32'h0);
    rd(16'h0014, v); chk("R5 next", v, 32'h0);
  endtask

  task automatic t_dip();
    logic [31:0] v;
    @(negedge clk); dip_in = 8'h3C;
    @(negedge clk);
    rd(16'h000C, v); chk("R4 dip", v, 32'h3C);
    @(negedge clk); dip_in = 8'hC1;
    rd(16'h000C, v); chk("R4 sync delay", v, 32'h3C);
    rd(16'h000C, v); chk("R4 dip new", v, 32'hC1);
  endtask

  task automatic t_bad_keys();
    int p0 = pulse_cnt;
    wr(16'h0010, 32'h0000_DEAE);
    wr(16'h0010, 32'h0001_DEAD);
    wr(16'h0010, 32'h0000_0000);
    repeat (2) @(negedge clk);
    chk("R7 no pulse", pulse_cnt - p0, 0);
    chk("R7 led kept", {24'h0, led_out}, 32'hFF);
  endtask

  task automatic t_key();
    int p0 = pulse_cnt;
    wr(16'h0010, 32'h0000_DEAD);
    chk("R6 req high", {31'h0, board_rst_req}, 32'h1);
    @(negedge clk);
    chk("R6 req low", {31'h0, board_rst_req}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R6 one pulse", pulse_cnt - p0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_consts();
    t_led();
    t_ignored_writes();
    t_unmapped();
    t_dip();
    t_bad_keys();
    t_key();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule